// File: doc/BRIEF.md
# Parallel Interleaver Bank Address Mapper

A turbo decoder that runs several decoding engines side by side splits its block of N symbols into equal windows of W = N/M, one window per engine. Engine k handles index k*W + j at step j. Reads and writes through the interleaver then go to a scrambled address P(i). The decoder stores its data in M memory banks, each W rows deep. On every step this mapper takes the M interleaved addresses and gives each engine a bank number and a row inside that bank.

Bank and row are the quotient and remainder of the address divided by W. The division uses a short chain of compare-and-subtract stages against W scaled by powers of two, so no divider is needed. The mapper also flags a conflict in a cycle where two engines would use the same bank, or where the engines do not all share one row. Outputs are registered and appear one clock after the input strobe. The number of engines is a power of two (2, 4 or 8) and equals the number of banks.

Top module: `bmap_parallel_mapper`

## Requirements
- R1: For each lane k, the bank output is floor(a_k / WIN_LEN), where a_k is the address on lane k. Lane k occupies bits [k*ADDR_W +: ADDR_W] of `in_addr`, bits [k*BANK_W +: BANK_W] of `out_bank` and bits [k*ROW_W +: ROW_W] of `out_row`.
- R2: For each lane k, the row output is a_k mod WIN_LEN, which is always below WIN_LEN.
- R3: `out_valid` equals the value `in_valid` had on the previous rising clock edge.
- R4: While `in_valid` is low, `out_bank`, `out_row` and `out_conflict` hold their last values, whatever `in_addr` carries.
- R5: `out_conflict` is 1 when any two lanes resolve to the same bank.
- R6: `out_conflict` is 1 when the lanes do not all resolve to the same row, even if all banks are distinct.
- R7: `out_conflict` is 0 when every lane has a distinct bank and all lanes share one row. The engines of such a step cover every bank exactly once.
- R8: After a synchronous active-low reset, `out_valid`, `out_conflict` and every bank and row output are 0.
- R9: Addresses at window edges map correctly: 0 to bank 0 row 0, W-1 to bank 0 row W-1, W to bank 1 row 0, and N-1 to bank M-1 row W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A new set of lane addresses is present |
| in_addr | input | NUM_ENG*ADDR_W | Interleaved address for each lane, lane 0 in the low bits |
| out_valid | output | 1 | Registered results are valid for this cycle |
| out_bank | output | NUM_ENG*BANK_W | Bank number for each lane |
| out_row | output | NUM_ENG*ROW_W | Row inside the bank for each lane |
| out_conflict | output | 1 | Two lanes share a bank, or the rows are not all equal |

## Verification
The residue check in each lane assumes that every address is below NUM_ENG*WIN_LEN. With a larger address the last subtract stage would leave a remainder of W or more. The stimulus therefore draws every address, including the pseudo-random ones, from the range 0 to N-1. The distinct-bank property assumes only that the conflict flag is correct, so it holds for any address set in that range. The bench keeps `in_valid` low during reset, and the latency properties rely on this.

// File: rtl/bmap_pkg.sv
// Package: bmap_pkg
// Shared sizing helpers for the parallel bank address mapper.
// Assumes: engine counts and window lengths are positive.
package bmap_pkg;

    // Width needed to hold values 0..n-1, never less than one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction

endpackage

// File: rtl/bmap_lane_div.sv
// Module: bmap_lane_div
// Splits one interleaved address into a bank (quotient by WIN_LEN) and a
// row (remainder). It uses binary long division: one compare-subtract
// stage per bank bit, against WIN_LEN scaled by that bit's weight.
// Assumes: addr < (2**BANK_W)*WIN_LEN. The result is combinational.
module bmap_lane_div #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned WIN_LEN = 300,
    parameter int unsigned BANK_W  = 3,
    parameter int unsigned ROW_W   = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);

    // rem[b+1] enters stage b; rem[BANK_W] is the raw address.
    logic [ADDR_W-1:0] rem [BANK_W+1];

    assign rem[BANK_W] = addr;

    // One compare-subtract stage per quotient bit, most significant first.
    for (genvar b = BANK_W - 1; b >= 0; b--) begin : g_stage
        localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WIN_LEN * (2 ** b));
        assign bank[b] = (rem[b+1] >= STEP);
        assign rem[b]  = bank[b] ? (rem[b+1] - STEP) : rem[b+1];
    end

    assign row = rem[0][ROW_W-1:0];

    // Residue must land inside one window (R2).
    always_comb begin
        p_residue_range_r2: assert (rem[0] < ADDR_W'(WIN_LEN))
            else $error("residue %0d not below window length", rem[0]);
    end

endmodule

// File: rtl/bmap_contention.sv
// Module: bmap_contention
// Checks one step of lane results for access contention. It flags
// a shared bank between any pair of lanes, or any lane whose row
// differs from lane 0's row.
// Assumes: inputs are already resolved bank/row pairs; purely combinational.
module bmap_contention #(
    parameter int unsigned NUM_ENG = 8,
    parameter int unsigned BANK_W  = 3,
    parameter int unsigned ROW_W   = 9
) (
    input  logic [NUM_ENG-1:0][BANK_W-1:0] bank,
    input  logic [NUM_ENG-1:0][ROW_W-1:0]  row,
    output logic                           clash
);

    logic bank_hit;
    logic row_miss;

    // Pairwise search for two lanes landing in one bank.
    always_comb begin
        bank_hit = 1'b0;
        for (int i = 0; i < NUM_ENG; i++) begin
            for (int j = i + 1; j < NUM_ENG; j++) begin
                if (bank[i] == bank[j]) bank_hit = 1'b1;
            end
        end
    end

    // Any lane whose row departs from lane 0 breaks the lock-step pattern.
    always_comb begin
        row_miss = 1'b0;
        for (int k = 1; k < NUM_ENG; k++) begin
            if (row[k] != row[0]) row_miss = 1'b1;
        end
    end

    assign clash = bank_hit | row_miss;

endmodule

// File: rtl/bmap_parallel_mapper.sv
// Module: bmap_parallel_mapper
// Top of the parallel interleaver bank address mapper. Each cycle with
// in_valid high, the NUM_ENG lane addresses are turned into bank/row
// pairs and checked for contention. The results are registered, so
// they appear one clock later with out_valid.
// Assumes: NUM_ENG is a power of two (2, 4 or 8); every lane address is
// below NUM_ENG*WIN_LEN; in_valid is low while rst_n is low.
module bmap_parallel_mapper
    import bmap_pkg::*;
#(
    parameter int unsigned NUM_ENG = 8,
    parameter int unsigned WIN_LEN = 300,
    parameter int unsigned ADDR_W  = idx_width(NUM_ENG * WIN_LEN),
    parameter int unsigned BANK_W  = idx_width(NUM_ENG),
    parameter int unsigned ROW_W   = idx_width(WIN_LEN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NUM_ENG*ADDR_W-1:0]  in_addr,
    output logic                       out_valid,
    output logic [NUM_ENG*BANK_W-1:0]  out_bank,
    output logic [NUM_ENG*ROW_W-1:0]   out_row,
    output logic                       out_conflict
);

    localparam int unsigned BLK_LEN = NUM_ENG * WIN_LEN;

    logic [NUM_ENG-1:0][BANK_W-1:0] bank_d;
    logic [NUM_ENG-1:0][ROW_W-1:0]  row_d;
    logic                           clash_d;

    logic [NUM_ENG-1:0][BANK_W-1:0] bank_q;
    logic [NUM_ENG-1:0][ROW_W-1:0]  row_q;

    // One divider per engine lane.
    for (genvar k = 0; k < NUM_ENG; k++) begin : g_lane
        bmap_lane_div #(
            .ADDR_W  (ADDR_W),
            .WIN_LEN (WIN_LEN),
            .BANK_W  (BANK_W),
            .ROW_W   (ROW_W)
        ) u_div (
            .addr (in_addr[k*ADDR_W +: ADDR_W]),
            .bank (bank_d[k]),
            .row  (row_d[k])
        );
    end

    bmap_contention #(
        .NUM_ENG (NUM_ENG),
        .BANK_W  (BANK_W),
        .ROW_W   (ROW_W)
    ) u_contention (
        .bank  (bank_d),
        .row   (row_d),
        .clash (clash_d)
    );

    // Valid strobe pipeline: one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers: load on a valid step, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q       <= '0;
            row_q        <= '0;
            out_conflict <= 1'b0;
        end else if (in_valid) begin
            bank_q       <= bank_d;
            row_q        <= row_d;
            out_conflict <= clash_d;
        end
    end

    assign out_bank = bank_q;
    assign out_row  = row_q;

    // ---------------- assertions ----------------

    // Set of banks touched by the registered results.
    logic [NUM_ENG-1:0] bank_seen;
    always_comb begin
        bank_seen = '0;
        for (int k = 0; k < NUM_ENG; k++) bank_seen[bank_q[k]] = 1'b1;
    end

    p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_bank) && $stable(out_row) && $stable(out_conflict)));

    p_distinct_banks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_conflict) |-> ($countones(bank_seen) == NUM_ENG));

    // Addresses beyond the block break the divider's contract (R1).
    p_addr_in_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_addr[ADDR_W-1:0] < ADDR_W'(BLK_LEN)));

endmodule

// File: tb/bmap_parallel_mapper_test.sv
module bmap_parallel_mapper_test;

    localparam int M  = 8;
    localparam int W  = 300;
    localparam int N  = M * W;
    localparam int AW = 12;
    localparam int BW = 3;
    localparam int RW = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [M*AW-1:0]   in_addr = '0;
    logic              out_valid;
    logic [M*BW-1:0]   out_bank;
    logic [M*RW-1:0]   out_row;
    logic              out_conflict;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bmap_parallel_mapper #(.NUM_ENG(M), .WIN_LEN(W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_addr      (in_addr),
        .out_valid    (out_valid),
        .out_bank     (out_bank),
        .out_row      (out_row),
        .out_conflict (out_conflict)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected conflict from the requirements: shared bank or unequal rows.
    function automatic int exp_conflict(input int unsigned a [M]);
        int c;
        c = 0;
        for (int i = 0; i < M; i++) begin
            if ((a[i] % W) != (a[0] % W)) c = 1;
            for (int j = i + 1; j < M; j++)
                if ((a[i] / W) == (a[j] / W)) c = 1;
        end
        return c;
    endfunction

    // Drive one valid step at a falling edge and check the result one clock later.
    task automatic step(input int unsigned a [M], input string tag);
        @(negedge clk);
        for (int k = 0; k < M; k++) in_addr[k*AW +: AW] = AW'(a[k]);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R3 valid"}, int'(out_valid), 1);
        for (int k = 0; k < M; k++) begin
            chk({tag, " R1 bank"}, int'(out_bank[k*BW +: BW]), int'(a[k] / W));
            chk({tag, " R2 row"},  int'(out_row[k*RW +: RW]),  int'(a[k] % W));
        end
        chk({tag, " conflict R5/R6/R7"}, int'(out_conflict), exp_conflict(a));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R8 valid", int'(out_valid), 0);
        chk("R8 bank", int'(out_bank), 0);
        chk("R8 row", int'(out_row), 0);
        chk("R8 conflict", int'(out_conflict), 0);
    endtask

    task automatic t_examples();
        int unsigned a [M];
        a = '{1, 1501, 601, 2101, 1201, 301, 1801, 901};
        step(a, "example A R1 R7");
        chk("R1 lane1 bank 5", int'(out_bank[1*BW +: BW]), 5);
        a = '{1320, 420, 1920, 1020, 120, 1620, 720, 2220};
        step(a, "example B R1 R7");
        chk("R2 lane0 row 120", int'(out_row[0 +: RW]), 120);
        chk("R7 no clash", int'(out_conflict), 0);
    endtask

    task automatic t_bank_clash();
        int unsigned a [M];
        a = '{5, 305, 605, 905, 1205, 1505, 1805, 1805 - W};
        step(a, "shared bank R5");
        chk("R5 clash", int'(out_conflict), 1);
    endtask

    task automatic t_row_clash();
        int unsigned a [M];
        a = '{7, 307, 607, 907, 1207, 1507, 1807, 2108};
        step(a, "row mismatch R6");
        chk("R6 clash", int'(out_conflict), 1);
    endtask

    task automatic t_edges();
        int unsigned a [M];
        a = '{0, W - 1, W, N - 1, 2 * W - 1, 3 * W, 6 * W + 150, 5 * W + 299};
        step(a, "window edges R9");
        chk("R9 lane3 bank", int'(out_bank[3*BW +: BW]), M - 1);
        chk("R9 lane3 row", int'(out_row[3*RW +: RW]), W - 1);
        chk("R9 lane2 bank", int'(out_bank[2*BW +: BW]), 1);
        chk("R9 lane2 row", int'(out_row[2*RW +: RW]), 0);
    endtask

    task automatic t_hold();
        logic [M*BW-1:0] b0;
        logic [M*RW-1:0] r0;
        logic c0;
        b0 = out_bank; r0 = out_row; c0 = out_conflict;
        @(negedge clk);
        for (int k = 0; k < M; k++) in_addr[k*AW +: AW] = AW'(k * 17 + 1000);
        @(negedge clk);
        chk("R3 valid low", int'(out_valid), 0);
        chk("R4 bank held", int'(out_bank == b0), 1);
        chk("R4 row held", int'(out_row == r0), 1);
        chk("R4 conflict held", int'(out_conflict == c0), 1);
    endtask

    task automatic t_sweep();
        int unsigned a [M];
        for (int s = 0; s < 40; s++) begin
            int unsigned j;
            j = (s * 37) % W;
            for (int k = 0; k < M; k++) a[k] = ((k * 3 + s) % M) * W + j;
            step(a, "rotated R7");
        end
    endtask

    task automatic t_random();
        int unsigned a [M];
        int unsigned seed;
        seed = 32'h1234_5678;
        for (int s = 0; s < 40; s++) begin
            for (int k = 0; k < M; k++) begin
                seed = seed * 1103515245 + 12345;
                a[k] = (seed >> 8) % N;
            end
            step(a, "random R1 R2 R5");
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_examples();
        t_bank_clash();
        t_row_clash();
        t_edges();
        t_hold();
        t_sweep();
        t_random();
        repeat (2) @(negedge clk);
        finish_up();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule